// File: doc/BRIEF.md
# Debug CPU Control Scan Handler

This block sits behind a JTAG TAP on the target side of a debug link. While the TAP is in Shift-DR, it takes one command bit per TCK on TDI and drives response bits on TDO. A frame either selects which debug sub-module is active or addresses a small CPU control register that holds the processor stall and reset lines. Every request frame carries a 32-bit CRC. The response returns a 4-bit status followed by a 32-bit CRC computed over the bits it sends back. When the host sees a nonzero status or a bad response CRC, it repeats the whole scan.

The TAP controller supplies three one-cycle strobes: capture (frame start), shift (one bit moves) and update (end of scan). The block restarts its bit counter and CRC engines on capture. It checks the frame as it shifts in and commits a valid select or write only on update. A frame that fails its CRC, is cut short or is not understood changes nothing.

Top module: `dbg_cpu_ctrl_scan`

## Requirements
- R1: After reset, cpu_stall_o and cpu_reset_o are 0, module_o equals the reset module value (default 0), and tdo_o is 0.
- R2: A select frame has bit 0 = 1, then a 4-bit module identifier sent most-significant bit first, then a 32-bit CRC. On update, if the CRC was good, module_o takes the identifier. module_o never changes without an update.
- R3: Each CRC starts at all ones and consumes bits in shift order. For each bit it shifts left and XORs in 0x04C11DB7 when the bit differs from the old MSB. A received CRC is sent MSB first and covers every earlier bit of the frame. On a mismatch the status is 1 and update has no effect.
- R4: A write frame has bit 0 = 0 and opcode 4 in bits 1..4, sent MSB first. It carries a 52-bit payload in which bit 5 is reset and bit 6 is stall, then a CRC over bits 0..56 in bits 57..88. On a good update, cpu_reset_o and cpu_stall_o take the two payload bits. Both hold their values until the next good write.
- R5: A read frame has opcode 4'h3 and a CRC in bits 5..36. Bits 37..88 of the response carry the payload: reset first, then stall, then zeros. Bits 89..92 carry the status, least-significant bit first. Bits 93..124 carry the CRC over response bits 37..92, MSB first.
- R6: The response to a select frame carries the status in bits 37..40, LSB first, then the CRC over those four bits in bits 41..72, MSB first.
- R7: The response to a write frame carries the status in bits 89..92 and its CRC in bits 93..124.
- R8: A command frame is any frame with bit 0 = 0. Such a frame is treated as not understood if the selected module is not the CPU module (identifier 1) or its opcode is neither 3 nor 4. It then has the short layout (CRC in bits 5..36), returns status 2 in bits 37..40 with its CRC in bits 41..72, and has no effect.
- R9: An update that comes before the frame's CRC field has been fully shifted in has no effect.
- R10: tdo_o is 0 when shift is low and in every shifted bit outside the response fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck_i | input | 1 | Test clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| capture_i | input | 1 | Frame start strobe (Capture-DR) |
| shift_i | input | 1 | Shift one bit this cycle (Shift-DR) |
| update_i | input | 1 | Commit strobe (Update-DR) |
| tdi_i | input | 1 | Serial command bit |
| tdo_o | output | 1 | Serial response bit |
| cpu_stall_o | output | 1 | Processor stall request |
| cpu_reset_o | output | 1 | Processor reset request |
| module_o | output | 4 | Currently selected debug sub-module |

## Verification
Committing one frame and starting the next can fall in the same cycle: an update strobe that lands on the same edge as the next capture strobe. The bench provokes this by raising both strobes together after a good write frame. It then expects the stall and reset outputs to change at that edge, and it expects the immediately following read frame to start from bit zero and report the new values in its payload. A wrong result would show up as a lost write, as a read frame whose bits are offset, or as a read payload that still shows the old register value.

// File: rtl/dbg_scan_pkg.sv
package dbg_scan_pkg;

   typedef enum logic [1:0] {
      FK_SELECT = 2'd0,
      FK_READ   = 2'd1,
      FK_WRITE  = 2'd2,
      FK_BAD    = 2'd3
   } frame_kind_e;

   // control register layout: bit order is behaviour (payload order)
   localparam int CTRL_W         = 2;
   localparam int CTRL_IDX_W     = 1;
   localparam int CTRL_RESET_BIT = 0;
   localparam int CTRL_STALL_BIT = 1;

   localparam int ST_OK  = 0;
   localparam int ST_CRC = 1;
   localparam int ST_CMD = 2;

endpackage

// File: rtl/dbg_crc_serial.sv
module dbg_crc_serial #(
   parameter int              CRC_W    = 32,
   parameter logic [CRC_W-1:0] CRC_POLY = 32'h04C11DB7
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             init_i,
   input  logic             en_i,
   input  logic             bit_i,
   output logic [CRC_W-1:0] crc_o
);

   logic [CRC_W-1:0] crc_q;
   logic             feedback;

   assign feedback = bit_i ^ crc_q[CRC_W-1];

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         crc_q <= '1;
      end else if (init_i) begin
         crc_q <= '1;
      end else if (en_i) begin
         crc_q <= {crc_q[CRC_W-2:0], 1'b0} ^ (feedback ? CRC_POLY : '0);
      end
   end

   assign crc_o = crc_q;

endmodule

// File: rtl/dbg_frame_rx.sv
module dbg_frame_rx
   import dbg_scan_pkg::*;
#(
   parameter int               ID_W      = 4,
   parameter int               PAYLOAD_W = 52,
   parameter int               CRC_W     = 32,
   parameter logic [CRC_W-1:0] CRC_POLY  = 32'h04C11DB7,
   parameter int               CNT_W     = 7,
   parameter logic [ID_W-1:0]  CPU_ID    = 4'h1,
   parameter logic [ID_W-1:0]  OP_READ   = 4'h3,
   parameter logic [ID_W-1:0]  OP_WRITE  = 4'h4
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              capture_i,
   input  logic              shift_i,
   input  logic              tdi_i,
   input  logic [ID_W-1:0]   cur_module_i,
   output logic [CNT_W-1:0]  cnt_o,
   output frame_kind_e       kind_o,
   output logic [ID_W-1:0]   id_o,
   output logic [CTRL_W-1:0] ctrl_o,
   output logic [CNT_W-1:0]  resp_start_o,
   output logic              done_o,
   output logic              crc_ok_o
);

   localparam int HDR_LEN = 1 + ID_W;
   localparam logic [CNT_W-1:0] L_HDR    = CNT_W'(HDR_LEN);
   localparam logic [CNT_W-1:0] L_LONG   = CNT_W'(HDR_LEN + PAYLOAD_W);
   localparam logic [CNT_W-1:0] L_CRC    = CNT_W'(CRC_W);
   localparam logic [CNT_W-1:0] L_PAYEND = CNT_W'(HDR_LEN + CTRL_W);
   localparam logic [CNT_W-1:0] L_MAX    = '1;

   logic [CNT_W-1:0]  cnt_q;
   logic              flag_q;
   logic [ID_W-1:0]   hdr_q;
   logic [CTRL_W-1:0] pay_q;
   logic [CRC_W-1:0]  rx_crc_q;
   logic [CRC_W-1:0]  calc_crc;
   logic [CNT_W-1:0]  crc_start;
   logic [CNT_W-1:0]  crc_end;
   logic [CNT_W-1:0]  pay_off;
   logic              step;

   assign step = shift_i && !capture_i;

   // frame kind is meaningful once the header bits are in
   always_comb begin
      if (flag_q) begin
         kind_o = FK_SELECT;
      end else if (cur_module_i != CPU_ID) begin
         kind_o = FK_BAD;
      end else if (hdr_q == OP_READ) begin
         kind_o = FK_READ;
      end else if (hdr_q == OP_WRITE) begin
         kind_o = FK_WRITE;
      end else begin
         kind_o = FK_BAD;
      end
   end

   always_comb begin
      crc_start = (kind_o == FK_WRITE) ? L_LONG : L_HDR;
      crc_end   = crc_start + L_CRC;
      pay_off   = cnt_q - L_HDR;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q    <= '0;
         flag_q   <= 1'b0;
         hdr_q    <= '0;
         pay_q    <= '0;
         rx_crc_q <= '0;
      end else if (capture_i) begin
         cnt_q    <= '0;
         flag_q   <= 1'b0;
         hdr_q    <= '0;
         pay_q    <= '0;
         rx_crc_q <= '0;
      end else if (step) begin
         if (cnt_q != L_MAX) begin
            cnt_q <= cnt_q + 1'b1;
         end
         if (cnt_q == '0) begin
            flag_q <= tdi_i;
         end
         if (cnt_q != '0 && cnt_q < L_HDR) begin
            hdr_q <= {hdr_q[ID_W-2:0], tdi_i};
         end
         if (kind_o == FK_WRITE && cnt_q >= L_HDR && cnt_q < L_PAYEND) begin
            pay_q[pay_off[CTRL_IDX_W-1:0]] <= tdi_i;
         end
         if (cnt_q >= crc_start && cnt_q < crc_end) begin
            rx_crc_q <= {rx_crc_q[CRC_W-2:0], tdi_i};
         end
      end
   end

   dbg_crc_serial #(
      .CRC_W    (CRC_W),
      .CRC_POLY (CRC_POLY)
   ) i_crc_rx (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .init_i (capture_i),
      .en_i   (step && (cnt_q < crc_start)),
      .bit_i  (tdi_i),
      .crc_o  (calc_crc)
   );

   assign cnt_o        = cnt_q;
   assign id_o         = hdr_q;
   assign ctrl_o       = pay_q;
   assign resp_start_o = crc_end;
   assign done_o       = (cnt_q >= crc_end);
   assign crc_ok_o     = done_o && (rx_crc_q == calc_crc);

endmodule

// File: rtl/dbg_resp_tx.sv
module dbg_resp_tx
   import dbg_scan_pkg::*;
#(
   parameter int               STATUS_W  = 4,
   parameter int               PAYLOAD_W = 52,
   parameter int               CRC_W     = 32,
   parameter logic [CRC_W-1:0] CRC_POLY  = 32'h04C11DB7,
   parameter int               CNT_W     = 7
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic                capture_i,
   input  logic                shift_i,
   input  logic [CNT_W-1:0]    cnt_i,
   input  frame_kind_e         kind_i,
   input  logic [CNT_W-1:0]    resp_start_i,
   input  logic [STATUS_W-1:0] status_i,
   input  logic [CTRL_W-1:0]   ctrl_i,
   output logic                tdo_o
);

   localparam int SIDX_W = $clog2(STATUS_W);
   localparam int CIDX_W = $clog2(CRC_W);
   localparam logic [CNT_W-1:0]  L_PAY  = CNT_W'(PAYLOAD_W);
   localparam logic [CNT_W-1:0]  L_STW  = CNT_W'(STATUS_W);
   localparam logic [CNT_W-1:0]  L_CRC  = CNT_W'(CRC_W);
   localparam logic [CNT_W-1:0]  L_CTRL = CNT_W'(CTRL_W);
   localparam logic [CIDX_W-1:0] L_CTOP = CIDX_W'(CRC_W - 1);

   logic [CNT_W-1:0] stat_start;
   logic [CNT_W-1:0] crco_start;
   logic [CNT_W-1:0] resp_end;
   logic [CNT_W-1:0] off_pay;
   logic [CNT_W-1:0] off_st;
   logic [CNT_W-1:0] off_crc;
   logic [CRC_W-1:0] crc_tx;
   logic             resp_bit;
   logic             crc_en;

   always_comb begin
      stat_start = resp_start_i + ((kind_i == FK_READ) ? L_PAY : '0);
      crco_start = stat_start + L_STW;
      resp_end   = crco_start + L_CRC;
      off_pay    = cnt_i - resp_start_i;
      off_st     = cnt_i - stat_start;
      off_crc    = cnt_i - crco_start;
   end

   always_comb begin
      resp_bit = 1'b0;
      if (kind_i == FK_READ && cnt_i >= resp_start_i && cnt_i < stat_start) begin
         if (off_pay < L_CTRL) begin
            resp_bit = ctrl_i[off_pay[CTRL_IDX_W-1:0]];
         end
      end else if (cnt_i >= stat_start && cnt_i < crco_start) begin
         resp_bit = status_i[off_st[SIDX_W-1:0]];
      end else if (cnt_i >= crco_start && cnt_i < resp_end) begin
         resp_bit = crc_tx[L_CTOP - off_crc[CIDX_W-1:0]];
      end
   end

   assign crc_en = shift_i && !capture_i && cnt_i >= resp_start_i && cnt_i < crco_start;

   dbg_crc_serial #(
      .CRC_W    (CRC_W),
      .CRC_POLY (CRC_POLY)
   ) i_crc_tx (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .init_i (capture_i),
      .en_i   (crc_en),
      .bit_i  (resp_bit),
      .crc_o  (crc_tx)
   );

   assign tdo_o = shift_i & resp_bit;

endmodule

// File: rtl/dbg_cpu_ctrl_scan.sv
module dbg_cpu_ctrl_scan
   import dbg_scan_pkg::*;
#(
   parameter int               ID_W         = 4,
   parameter int               PAYLOAD_W    = 52,
   parameter int               STATUS_W     = 4,
   parameter int               CRC_W        = 32,
   parameter logic [CRC_W-1:0] CRC_POLY     = 32'h04C11DB7,
   parameter logic [ID_W-1:0]  CPU_ID       = 4'h1,
   parameter logic [ID_W-1:0]  OP_READ      = 4'h3,
   parameter logic [ID_W-1:0]  OP_WRITE     = 4'h4,
   parameter logic [ID_W-1:0]  RESET_MODULE = 4'h0
) (
   input  logic            tck_i,
   input  logic            rst_ni,
   input  logic            capture_i,
   input  logic            shift_i,
   input  logic            update_i,
   input  logic            tdi_i,
   output logic            tdo_o,
   output logic            cpu_stall_o,
   output logic            cpu_reset_o,
   output logic [ID_W-1:0] module_o
);

   localparam int FRAME_MAX = 1 + ID_W + PAYLOAD_W + CRC_W + STATUS_W + CRC_W;
   localparam int CNT_W     = $clog2(FRAME_MAX + 2);

   if (ID_W < 2) begin : g_chk_id
      $error("ID_W must be at least 2");
   end
   if (PAYLOAD_W < CTRL_W) begin : g_chk_pay
      $error("PAYLOAD_W must hold the control bits");
   end
   if (STATUS_W < 2) begin : g_chk_st
      $error("STATUS_W must be at least 2");
   end
   if ((CRC_W & (CRC_W - 1)) != 0 || CRC_W < 8) begin : g_chk_crc
      $error("CRC_W must be a power of two of at least 8");
   end

   logic [CNT_W-1:0]    bit_cnt;
   frame_kind_e         kind;
   logic [ID_W-1:0]     rx_id;
   logic [CTRL_W-1:0]   rx_ctrl;
   logic [CNT_W-1:0]    resp_start;
   logic                frame_done;
   logic                crc_ok;
   logic [STATUS_W-1:0] status;
   logic [ID_W-1:0]     module_q;
   logic [CTRL_W-1:0]   ctrl_q;
   logic                apply_sel;
   logic                apply_wr;

   dbg_frame_rx #(
      .ID_W      (ID_W),
      .PAYLOAD_W (PAYLOAD_W),
      .CRC_W     (CRC_W),
      .CRC_POLY  (CRC_POLY),
      .CNT_W     (CNT_W),
      .CPU_ID    (CPU_ID),
      .OP_READ   (OP_READ),
      .OP_WRITE  (OP_WRITE)
   ) i_rx (
      .clk_i        (tck_i),
      .rst_ni       (rst_ni),
      .capture_i    (capture_i),
      .shift_i      (shift_i),
      .tdi_i        (tdi_i),
      .cur_module_i (module_q),
      .cnt_o        (bit_cnt),
      .kind_o       (kind),
      .id_o         (rx_id),
      .ctrl_o       (rx_ctrl),
      .resp_start_o (resp_start),
      .done_o       (frame_done),
      .crc_ok_o     (crc_ok)
   );

   always_comb begin
      if (!crc_ok) begin
         status = STATUS_W'(ST_CRC);
      end else if (kind == FK_BAD) begin
         status = STATUS_W'(ST_CMD);
      end else begin
         status = STATUS_W'(ST_OK);
      end
   end

   dbg_resp_tx #(
      .STATUS_W  (STATUS_W),
      .PAYLOAD_W (PAYLOAD_W),
      .CRC_W     (CRC_W),
      .CRC_POLY  (CRC_POLY),
      .CNT_W     (CNT_W)
   ) i_tx (
      .clk_i        (tck_i),
      .rst_ni       (rst_ni),
      .capture_i    (capture_i),
      .shift_i      (shift_i),
      .cnt_i        (bit_cnt),
      .kind_i       (kind),
      .resp_start_i (resp_start),
      .status_i     (status),
      .ctrl_i       (ctrl_q),
      .tdo_o        (tdo_o)
   );

   // commit happens only on update, and only for a complete clean frame
   assign apply_sel = update_i && crc_ok && (kind == FK_SELECT);
   assign apply_wr  = update_i && crc_ok && (kind == FK_WRITE);

   always_ff @(posedge tck_i or negedge rst_ni) begin
      if (!rst_ni) begin
         module_q <= RESET_MODULE;
         ctrl_q   <= '0;
      end else begin
         if (apply_sel) begin
            module_q <= rx_id;
         end
         if (apply_wr) begin
            ctrl_q <= rx_ctrl;
         end
      end
   end

   assign module_o    = module_q;
   assign cpu_stall_o = ctrl_q[CTRL_STALL_BIT];
   assign cpu_reset_o = ctrl_q[CTRL_RESET_BIT];

endmodule

// File: rtl/dbg_cpu_ctrl_scan_chk.sv
module dbg_cpu_ctrl_scan_chk #(
   parameter int ID_W  = 4,
   parameter int CNT_W = 7
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic             shift_i,
   input logic             update_i,
   input logic             tdo_o,
   input logic             cpu_stall_o,
   input logic             cpu_reset_o,
   input logic [ID_W-1:0]  module_o,
   input logic [CNT_W-1:0] bit_cnt,
   input logic             frame_done,
   input logic             crc_ok
);

   localparam logic [CNT_W-1:0] L_HDR = CNT_W'(1 + ID_W);

   // R2: module register moves only on an update
   a_r2_module_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !update_i |=> $stable(module_o));

   // R4: control outputs move only on an update
   a_r4_ctrl_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !update_i |=> ($stable(cpu_stall_o) && $stable(cpu_reset_o)));

   // R3: a complete frame with a bad CRC commits nothing
   a_r3_bad_crc_no_effect: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (update_i && frame_done && !crc_ok) |=>
         ($stable(module_o) && $stable(cpu_stall_o) && $stable(cpu_reset_o)));

   // R9: a truncated frame commits nothing
   a_r9_truncated_no_effect: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (update_i && !frame_done) |=>
         ($stable(module_o) && $stable(cpu_stall_o) && $stable(cpu_reset_o)));

   // R10: nothing is driven back during the header bits
   a_r10_quiet_header: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (shift_i && bit_cnt < L_HDR) |-> !tdo_o);

endmodule

bind dbg_cpu_ctrl_scan dbg_cpu_ctrl_scan_chk #(
   .ID_W  (ID_W),
   .CNT_W (CNT_W)
) i_chk (
   .clk_i       (tck_i),
   .rst_ni      (rst_ni),
   .shift_i     (shift_i),
   .update_i    (update_i),
   .tdo_o       (tdo_o),
   .cpu_stall_o (cpu_stall_o),
   .cpu_reset_o (cpu_reset_o),
   .module_o    (module_o),
   .bit_cnt     (bit_cnt),
   .frame_done  (frame_done),
   .crc_ok      (crc_ok)
);

// File: tb/test_dbg_cpu_ctrl_scan.sv
`timescale 1ns/1ps
module test_dbg_cpu_ctrl_scan;

   localparam logic [31:0] POLY   = 32'h04C11DB7;
   localparam logic [3:0]  CPU_ID = 4'h1;
   localparam int K_SEL = 0, K_READ = 1, K_WRITE = 2, K_BAD = 3;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cap = 1'b0, sh = 1'b0, upd = 1'b0, tdi = 1'b0;
   logic       tdo, stall, creset;
   logic [3:0] module_o;

   int checks = 0;
   int errors = 0;

   // reference model state
   logic       m_stall = 1'b0, m_reset = 1'b0;
   logic [3:0] m_mod = 4'h0;
   bit         p_valid = 1'b0;
   int         p_kind = K_BAD;
   logic [3:0] p_id = 4'h0;
   logic       p_rst = 1'b0, p_stl = 1'b0;
   bit         merge = 1'b0;

   always #4 clk = ~clk;

   dbg_cpu_ctrl_scan i_dbg_cpu_ctrl_scan (
      .tck_i       (clk),
      .rst_ni      (rst_n),
      .capture_i   (cap),
      .shift_i     (sh),
      .update_i    (upd),
      .tdi_i       (tdi),
      .tdo_o       (tdo),
      .cpu_stall_o (stall),
      .cpu_reset_o (creset),
      .module_o    (module_o)
   );

   function automatic logic [31:0] crc_of(input bit q[$]);
      logic [31:0] c = '1;
      foreach (q[i]) begin
         logic fb = q[i] ^ c[31];
         c = {c[30:0], 1'b0} ^ (fb ? POLY : 32'h0);
      end
      return c;
   endfunction

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic cycle(input logic c, input logic s, input logic u, input logic d,
                        input logic e, input string tag);
      @(negedge clk);
      cap = c; sh = s; upd = u; tdi = d;
      #1;
      check(s ? tag : "R10", {63'b0, tdo}, {63'b0, e});
      check("R4 stall", {63'b0, stall}, {63'b0, m_stall});
      check("R4 reset", {63'b0, creset}, {63'b0, m_reset});
      check("R2 module", {60'b0, module_o}, {60'b0, m_mod});
      @(posedge clk);
      if (u && p_valid) begin
         if (p_kind == K_SEL) m_mod = p_id;
         if (p_kind == K_WRITE) begin m_reset = p_rst; m_stall = p_stl; end
      end
      if (c) p_valid = 1'b0;
   endtask

   // typ: 0 select, 1 short command, 2 write layout
   // umode: 0 none, 1 own update cycle, 2 update with next capture
   task automatic scan(input int typ, input logic [3:0] fld, input logic rb, input logic sb,
                       input bit corrupt, input int nshift, input int umode, input string tag);
      bit req[$];
      bit resp[$];
      logic [31:0] c;
      int kind, st, rs, full, n;
      cycle(1'b1, 1'b0, merge, 1'b0, 1'b0, tag);
      merge = 1'b0;
      req.push_back(typ == 0);
      for (int i = 3; i >= 0; i--) req.push_back(fld[i]);
      if (typ == 2) begin
         req.push_back(rb); req.push_back(sb);
         for (int i = 0; i < 50; i++) req.push_back(1'b0);
      end
      c = crc_of(req);
      if (corrupt) c[0] = ~c[0];
      for (int i = 31; i >= 0; i--) req.push_back(c[i]);
      if (typ == 0) kind = K_SEL;
      else if (m_mod != CPU_ID) kind = K_BAD;
      else if (fld == 4'h3) kind = K_READ;
      else if (fld == 4'h4) kind = K_WRITE;
      else kind = K_BAD;
      st = corrupt ? 1 : (kind == K_BAD ? 2 : 0);
      if (kind == K_READ) begin
         resp.push_back(m_reset); resp.push_back(m_stall);
         for (int i = 0; i < 50; i++) resp.push_back(1'b0);
      end
      for (int i = 0; i < 4; i++) resp.push_back(st[i]);
      c = crc_of(resp);
      for (int i = 31; i >= 0; i--) resp.push_back(c[i]);
      rs = req.size();
      full = rs + resp.size();
      n = (nshift < 0) ? full : nshift;
      for (int i = 0; i < n; i++) begin
         logic d = (i < rs) ? req[i] : 1'b0;
         logic e = (i >= rs && i - rs < resp.size()) ? resp[i - rs] : 1'b0;
         cycle(1'b0, 1'b1, 1'b0, d, e, tag);
      end
      if (n >= rs && !corrupt) begin
         p_valid = 1'b1; p_kind = kind; p_id = fld; p_rst = rb; p_stl = sb;
      end
      cycle(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, tag);
      if (umode == 1) begin
         cycle(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, tag);
         cycle(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, tag);
      end else if (umode == 2) begin
         merge = 1'b1;
      end
   endtask

   initial begin
      #(8 * 200000);
      checks++; errors++;
      $display("FAIL watchdog actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (2) @(negedge clk);
      #1;
      check("R1 stall", {63'b0, stall}, 64'd0);
      check("R1 reset", {63'b0, creset}, 64'd0);
      check("R1 module", {60'b0, module_o}, 64'd0);
      check("R1 tdo", {63'b0, tdo}, 64'd0);
      @(negedge clk);
      rst_n = 1'b1;
      // command while no CPU module selected: not understood
      scan(1, 4'h3, 0, 0, 0, -1, 1, "R8 no module");
      // good select of the CPU module
      scan(0, 4'h1, 0, 0, 0, -1, 1, "R6 select");
      // corrupted select must leave the module alone
      scan(0, 4'h5, 0, 0, 1, -1, 1, "R3 select crc");
      // write stall only
      scan(2, 4'h4, 0, 1, 0, -1, 1, "R7 write");
      // read back
      scan(1, 4'h3, 0, 0, 0, -1, 1, "R5 read");
      // corrupted write
      scan(2, 4'h4, 1, 1, 1, -1, 1, "R3 write crc");
      // truncated write then update
      scan(2, 4'h4, 1, 1, 0, 40, 1, "R9 truncated");
      // write with update on the next capture edge, then read immediately
      scan(2, 4'h4, 1, 1, 0, -1, 2, "R4 write merged");
      scan(1, 4'h3, 0, 0, 0, -1, 1, "R5 read after merge");
      // release reset, stall stays
      scan(2, 4'h4, 0, 1, 0, -1, 1, "R4 write release");
      // unknown opcode
      scan(1, 4'h7, 0, 0, 0, -1, 1, "R8 opcode");
      // select another module, command there is not understood
      scan(0, 4'h3, 0, 0, 0, -1, 1, "R2 select other");
      scan(1, 4'h3, 0, 0, 0, -1, 1, "R8 other module");
      scan(0, 4'h1, 0, 0, 0, -1, 1, "R2 select cpu");
      scan(1, 4'h3, 0, 0, 0, -1, 1, "R5 final read");
      repeat (3) cycle(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R10");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule